// File: doc/BRIEF.md
# Conflict-Free Banked FFT Address Generator

This block drives the memory addresses for an in-place 64-point transform. The 64 complex samples are stored across eight dual-port banks of eight words each. Each cycle of a pass, the block issues one group of eight samples (an octet), with one 3-bit address per bank on the read side. It also gives a lane rotation value, which tells the data crossbar which bank holds which octet member. Results go back to the same locations they were read from. The write side therefore replays every read address set a fixed number of cycles later, which matches the arithmetic pipeline depth.

Sample n = 8h + l is stored at word h of bank (h + l) mod 8. Under this placement, two kinds of octet each touch all eight banks exactly once:
- a stride octet (samples l, l+8, ..., l+56), used in the first three passes;
- a run of eight consecutive samples, used in the last three passes.

The stride addresses come from a rotated identity pattern through a logarithmic barrel rotator. The run addresses are the octet number copied to every lane. The address path has no adders. A short drain gap after each pass lets the last writes retire before the next pass reads. As a result, no bank word is ever read and written in the same cycle. A start pulse begins or restarts a run. Per-pass and end-of-run pulses mark the final write of each pass.

Top module: `fft_bank_agu`

## Requirements
- R1: While reset is held, and afterwards until the first start pulse, all outputs are zero.
- R2: A start pulse on a clock edge makes the first octet (pass 0, octet 0) appear on the read outputs in the very next cycle. Each pass issues octets 0..7 on eight consecutive cycles, with the rotation output equal to the octet number. Then LAT idle cycles follow. After six passes (48 octets) the block goes idle.
- R3: In passes 0..2, the read address of bank b for octet j is (b - j) mod 8. Lane b is bits [3b+2:3b] of the address bus.
- R4: In passes 3..5, every bank's read address for octet j equals j.
- R5: Within each pass, every one of the 64 (bank, word) locations is read exactly once.
- R6: The write valid, write rotation and write addresses equal the read valid, read rotation and read addresses from LAT cycles earlier (LAT = 4 by default).
- R7: No bank is given the same word on its read and write address in a cycle where both valids are high.
- R8: pass_done pulses in the cycle that carries the write of octet 7 of each pass. all_done pulses together with it for the last pass only.
- R9: A start pulse during a run restarts at pass 0, octet 0 in the next cycle. It discards all pending writes, so write valid stays low for the next LAT cycles.
- R10: When the read valid is low, the read addresses and read rotation are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart a 64-point run |
| rd_valid | output | 1 | Read addresses are meaningful this cycle |
| rd_rot | output | 3 | Lane rotation for the read crossbar (octet number) |
| rd_addr | output | 24 | Eight 3-bit read addresses, bank b in bits [3b+2:3b] |
| wr_valid | output | 1 | Write addresses are meaningful this cycle |
| wr_rot | output | 3 | Lane rotation for the write crossbar |
| wr_addr | output | 24 | Eight 3-bit write addresses, same lane layout |
| pass_done | output | 1 | Final write of a pass is on the write bus |
| all_done | output | 1 | Final write of the whole run is on the write bus |

## Verification
The read outputs come straight from the sequencing state. The first octet is therefore due in the first cycle after the edge that samples start, and octet k of pass p is due at cycle 12p + k of the run (with LAT = 4). Write outputs and the done pulses are due exactly LAT cycles after the matching read: cycle 12p + 11 for the last write of pass p, and cycle 71 for all_done.

The bench counts cycles from the start edge and samples every output at the falling edge of that exact cycle. A per-cycle monitor recomputes the bank placement arithmetically to check the address patterns, the coverage of each pass and read/write collisions. A restart test checks that the flushed writes stay silent for exactly LAT cycles.

// File: rtl/fft_agu_pkg.sv
package fft_agu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } agu_state_e;

endpackage

// File: rtl/fft_agu_seq.sv
module fft_agu_seq
    import fft_agu_pkg::*;
#(
    parameter int unsigned AW            = 3,
    parameter int unsigned PASSES        = 6,
    parameter int unsigned STRIDE_PASSES = 3,
    parameter int unsigned LAT           = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          issue,
    output logic [AW-1:0] octet,
    output logic          stride_mode,
    output logic          last_octet,
    output logic          final_pass
);

    localparam int unsigned PW = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam int unsigned DW = $clog2(LAT + 1);

    typedef struct packed {
        agu_state_e    st;
        logic [AW-1:0] oct;
        logic [PW-1:0] pass;
        logic [DW-1:0] drain;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.st    = ST_ISSUE;
            seq_d.oct   = '0;
            seq_d.pass  = '0;
            seq_d.drain = '0;
        end else begin
            case (seq_q.st)
                ST_ISSUE: begin
                    if (&seq_q.oct) begin
                        seq_d.st    = ST_DRAIN;
                        seq_d.oct   = '0;
                        seq_d.drain = DW'(LAT - 1);
                    end else begin
                        seq_d.oct = seq_q.oct + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (seq_q.drain == '0) begin
                        if (seq_q.pass == PW'(PASSES - 1)) begin
                            seq_d.st   = ST_IDLE;
                            seq_d.pass = '0;
                        end else begin
                            seq_d.st   = ST_ISSUE;
                            seq_d.pass = seq_q.pass + 1'b1;
                        end
                    end else begin
                        seq_d.drain = seq_q.drain - 1'b1;
                    end
                end
                default: seq_d = seq_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign issue       = (seq_q.st == ST_ISSUE);
    assign octet       = seq_q.oct;
    assign stride_mode = (seq_q.pass < PW'(STRIDE_PASSES));
    assign last_octet  = issue && (&seq_q.oct);
    assign final_pass  = (seq_q.pass == PW'(PASSES - 1));

endmodule

// File: rtl/fft_agu_map.sv
module fft_agu_map #(
    parameter int unsigned AW = 3
) (
    input  logic                    valid,
    input  logic [AW-1:0]           octet,
    input  logic                    stride_mode,
    output logic [(1<<AW)*AW-1:0]   addr,
    output logic [AW-1:0]           rot
);

    localparam int unsigned BANKS = 1 << AW;
    localparam int unsigned W     = BANKS * AW;

    // stg[0] holds word b in lane b; each stage rotates by 2^s lanes
    logic [W-1:0] stg [AW+1];
    logic [W-1:0] run_word;

    genvar b, s;
    generate
        for (b = 0; b < BANKS; b++) begin : g_ident
            assign stg[0][b*AW +: AW] = AW'(b);
        end
        for (s = 0; s < AW; s++) begin : g_rot
            localparam int unsigned SH = (1 << s) * AW;
            assign stg[s+1] = octet[s] ? {stg[s][W-SH-1:0], stg[s][W-1:W-SH]}
                                       : stg[s];
        end
    endgenerate

    assign run_word = {BANKS{octet}};

    always_comb begin
        if (!valid) begin
            addr = '0;
            rot  = '0;
        end else begin
            addr = stride_mode ? stg[AW] : run_word;
            rot  = octet;
        end
    end

endmodule

// File: rtl/fft_agu_delay.sv
module fft_agu_delay #(
    parameter int unsigned W   = 30,
    parameter int unsigned LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe_d [LAT];
    logic [W-1:0] pipe_q [LAT];

    always_comb begin
        pipe_d[0] = flush ? '0 : din;
        for (int i = 1; i < LAT; i++) begin
            pipe_d[i] = flush ? '0 : pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[LAT-1];

endmodule

// File: rtl/fft_bank_agu.sv
module fft_bank_agu #(
    parameter int unsigned AW            = 3,
    parameter int unsigned PASSES        = 6,
    parameter int unsigned STRIDE_PASSES = 3,
    parameter int unsigned LAT           = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  rd_valid,
    output logic [AW-1:0]         rd_rot,
    output logic [(1<<AW)*AW-1:0] rd_addr,
    output logic                  wr_valid,
    output logic [AW-1:0]         wr_rot,
    output logic [(1<<AW)*AW-1:0] wr_addr,
    output logic                  pass_done,
    output logic                  all_done
);

    localparam int unsigned BANKS = 1 << AW;
    localparam int unsigned AB    = BANKS * AW;
    localparam int unsigned PAYW  = AB + AW + 3;

    logic          issue;
    logic [AW-1:0] octet;
    logic          stride_mode;
    logic          last_octet;
    logic          final_pass;
    logic [PAYW-1:0] rd_pkt;
    logic [PAYW-1:0] wr_pkt;
    logic          wr_last;
    logic          wr_fin;

    fft_agu_seq #(
        .AW(AW), .PASSES(PASSES), .STRIDE_PASSES(STRIDE_PASSES), .LAT(LAT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .issue       (issue),
        .octet       (octet),
        .stride_mode (stride_mode),
        .last_octet  (last_octet),
        .final_pass  (final_pass)
    );

    fft_agu_map #(.AW(AW)) u_map (
        .valid       (issue),
        .octet       (octet),
        .stride_mode (stride_mode),
        .addr        (rd_addr),
        .rot         (rd_rot)
    );

    assign rd_valid = issue;
    assign rd_pkt   = {last_octet, last_octet & final_pass, issue, rd_rot, rd_addr};

    fft_agu_delay #(.W(PAYW), .LAT(LAT)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (start),
        .din   (rd_pkt),
        .dout  (wr_pkt)
    );

    assign {wr_last, wr_fin, wr_valid, wr_rot, wr_addr} = wr_pkt;
    assign pass_done = wr_last;
    assign all_done  = wr_fin;

endmodule

// File: rtl/fft_agu_chk.sv
module fft_agu_chk #(
    parameter int unsigned AW = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  rd_valid,
    input logic [AW-1:0]         rd_rot,
    input logic [(1<<AW)*AW-1:0] rd_addr,
    input logic                  wr_valid,
    input logic [AW-1:0]         wr_rot,
    input logic [(1<<AW)*AW-1:0] wr_addr,
    input logic                  pass_done,
    input logic                  all_done
);

    localparam int unsigned BANKS = 1 << AW;

    function automatic logic shape_ok(logic [(1<<AW)*AW-1:0] a, logic [AW-1:0] r);
        logic uni, rot_ok;
        uni    = 1'b1;
        rot_ok = 1'b1;
        for (int b = 0; b < BANKS; b++) begin
            uni    = uni    && (a[b*AW +: AW] == r);
            rot_ok = rot_ok && (AW'(a[b*AW +: AW] + r) == AW'(b));
        end
        return uni || rot_ok;
    endfunction

    genvar b;
    generate
        for (b = 0; b < BANKS; b++) begin : g_lane
            // R7
            p_no_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !(rd_valid && wr_valid && (rd_addr[b*AW +: AW] == wr_addr[b*AW +: AW])));
        end
    endgenerate

    p_rd_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> shape_ok(rd_addr, rd_rot));

    p_wr_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> shape_ok(wr_addr, wr_rot));

    p_rot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && (rd_rot != '0)) |-> (rd_rot == AW'($past(rd_rot) + 1'b1)));

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rd_valid && (rd_rot == '0) && !wr_valid));

    p_done_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (wr_valid && (&wr_rot)));

    p_all_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> pass_done);

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> ((rd_addr == '0) && (rd_rot == '0)));

endmodule

bind fft_bank_agu fft_agu_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_valid  (rd_valid),
    .rd_rot    (rd_rot),
    .rd_addr   (rd_addr),
    .wr_valid  (wr_valid),
    .wr_rot    (wr_rot),
    .wr_addr   (wr_addr),
    .pass_done (pass_done),
    .all_done  (all_done)
);

// File: tb/fft_bank_agu_bench.sv
`timescale 1ns/1ps
module fft_bank_agu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_valid, wr_valid, pass_done, all_done;
    logic [2:0]  rd_rot, wr_rot;
    logic [23:0] rd_addr, wr_addr;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fft_bank_agu u_fft_bank_agu (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_valid(rd_valid), .rd_rot(rd_rot), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_rot(wr_rot), .wr_addr(wr_addr),
        .pass_done(pass_done), .all_done(all_done)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    typedef struct packed {
        logic [7:0]  off;
        logic        rv;
        logic [2:0]  rr;
        logic [23:0] ra;
        logic        wv;
        logic [2:0]  wr;
        logic [23:0] wa;
        logic        pd;
        logic        ad;
    } vec_t;

    localparam vec_t TAB [10] = '{
        '{8'd0,  1'b1, 3'd0, 24'hFAC688, 1'b0, 3'd0, 24'h000000, 1'b0, 1'b0},
        '{8'd3,  1'b1, 3'd3, 24'h8D11F5, 1'b0, 3'd0, 24'h000000, 1'b0, 1'b0},
        '{8'd4,  1'b1, 3'd4, 24'h688FAC, 1'b1, 3'd0, 24'hFAC688, 1'b0, 1'b0},
        '{8'd8,  1'b0, 3'd0, 24'h000000, 1'b1, 3'd4, 24'h688FAC, 1'b0, 1'b0},
        '{8'd11, 1'b0, 3'd0, 24'h000000, 1'b1, 3'd7, 24'h1F58D1, 1'b1, 1'b0},
        '{8'd36, 1'b1, 3'd0, 24'h000000, 1'b0, 3'd0, 24'h000000, 1'b0, 1'b0},
        '{8'd41, 1'b1, 3'd5, 24'hB6DB6D, 1'b1, 3'd1, 24'h249249, 1'b0, 1'b0},
        '{8'd43, 1'b1, 3'd7, 24'hFFFFFF, 1'b1, 3'd3, 24'h6DB6DB, 1'b0, 1'b0},
        '{8'd71, 1'b0, 3'd0, 24'h000000, 1'b1, 3'd7, 24'hFFFFFF, 1'b1, 1'b1},
        '{8'd72, 1'b0, 3'd0, 24'h000000, 1'b0, 3'd0, 24'h000000, 1'b0, 1'b0}
    };

    // per-cycle monitor: placement pattern, coverage and collisions
    bit mon_on = 1'b0;
    int oct_cnt = 0;
    int touched [6][64];

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (rd_valid) begin
                int p, j;
                bit ok;
                p  = oct_cnt / 8;
                j  = oct_cnt % 8;
                ok = 1'b1;
                for (int b = 0; b < 8; b++) begin
                    int a;
                    a = int'(rd_addr[b*3 +: 3]);
                    if (p < 3) ok = ok && (((b - a + 8) % 8) == j);
                    else       ok = ok && (a == j);
                    if (p < 6) touched[p][b*8 + a]++;
                end
                if (p < 3) chk("R3 stride pattern", {31'd0, ok}, 32'd1);
                else       chk("R4 run pattern", {31'd0, ok}, 32'd1);
                chk("R2 rotation", {29'd0, rd_rot}, j);
                oct_cnt++;
            end
            if (rd_valid && wr_valid) begin
                bit clash;
                clash = 1'b0;
                for (int b = 0; b < 8; b++)
                    if (rd_addr[b*3 +: 3] == wr_addr[b*3 +: 3]) clash = 1'b1;
                chk("R7 read/write clash", {31'd0, clash}, 32'd0);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        nerr++;
        nchk++;
        $display("FAIL watchdog expired act=hung exp=done");
        summary();
    end

    initial begin
        int cur;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rd_valid in reset", {31'd0, rd_valid}, 0);
        chk("R1 wr_valid in reset", {31'd0, wr_valid}, 0);
        chk("R1 addrs in reset", rd_addr | wr_addr, 0);
        chk("R1 done in reset", {30'd0, pass_done, all_done}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle without start", {29'd0, rd_valid, wr_valid, pass_done}, 0);

        // full run walked against the vector table
        for (int p = 0; p < 6; p++)
            for (int k = 0; k < 64; k++) touched[p][k] = 0;
        oct_cnt = 0;
        mon_on  = 1'b1;
        pulse_start();
        cur = 0;
        for (int i = 0; i < 10; i++) begin
            while (cur < int'(TAB[i].off)) begin
                @(negedge clk);
                cur++;
            end
            chk("R2 rd_valid", {31'd0, rd_valid}, {31'd0, TAB[i].rv});
            chk("R2 rd_rot", {29'd0, rd_rot}, {29'd0, TAB[i].rr});
            chk(TAB[i].rv ? "R3 rd_addr" : "R10 rd_addr idle", {8'd0, rd_addr}, {8'd0, TAB[i].ra});
            chk("R6 wr_valid", {31'd0, wr_valid}, {31'd0, TAB[i].wv});
            chk("R6 wr_rot", {29'd0, wr_rot}, {29'd0, TAB[i].wr});
            chk("R6 wr_addr", {8'd0, wr_addr}, {8'd0, TAB[i].wa});
            chk("R8 pass_done", {31'd0, pass_done}, {31'd0, TAB[i].pd});
            chk("R8 all_done", {31'd0, all_done}, {31'd0, TAB[i].ad});
        end
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
        chk("R2 octets per run", oct_cnt, 48);
        for (int p = 0; p < 6; p++) begin
            bit once;
            once = 1'b1;
            for (int k = 0; k < 64; k++) if (touched[p][k] != 1) once = 1'b0;
            chk("R5 each location once per pass", {31'd0, once}, 1);
        end

        // R9: restart in the drain of pass 1 with writes pending
        pulse_start();
        repeat (20) @(negedge clk);
        chk("R9 writes pending before restart", {31'd0, wr_valid}, 1);
        pulse_start();
        chk("R9 restart rd_valid", {31'd0, rd_valid}, 1);
        chk("R9 restart rd_rot", {29'd0, rd_rot}, 0);
        chk("R9 restart rd_addr", {8'd0, rd_addr}, 32'h00FAC688);
        for (int k = 0; k < 4; k++) begin
            chk("R9 flushed write", {31'd0, wr_valid}, 0);
            @(negedge clk);
        end
        chk("R6 first write after restart", {31'd0, wr_valid}, 1);
        chk("R6 first write addr after restart", {8'd0, wr_addr}, 32'h00FAC688);

        summary();
    end

endmodule